// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave-side logic of a small serial EEPROM that sits on an SPI bus. A bus master selects it with an active-low chip select and sends an opcode. Depending on the opcode, the master then sends a 16-bit address and clocks data in or out. The block stores data in an on-chip byte array. It keeps a write-enable latch and a small status register, and it can pause a transfer mid-frame when the master pulls a hold input low.

Writes do not take effect at once. When a correctly framed write ends, a busy timer in the system clock domain starts. The byte array, or the protect field of the status register, is updated only when that timer expires. While the timer runs, every instruction except the status read is dropped. All SPI inputs are sampled by the system clock, which acts as the synchronous stand-in for power-on reset. The inputs must arrive already synchronised to that clock, and SCK must be much slower than it.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, so_oe is low, the write-enable latch is clear, the busy flag is clear and the protect field is 0. A status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Status bit1 reports the latch.
- R3: A write (opcode 0x02, two address bytes, then data) made while the latch is clear is discarded. It starts no busy period and leaves the array unchanged.
- R4: Rules for an accepted write:
  - It starts a busy period only when CS_n rises.
  - The busy period lasts BUSY_CYCLES system clocks, and status bit0 reports it.
  - The latch clears when the busy period starts.
  - The written bytes can be read back once the busy period has ended.
- R5: A write frame is discarded, and the latch stays set, in two cases: when CS_n rises after a bit count that is not a whole number of bytes, or when the frame holds no data byte.
- R6: Data bytes in one write frame go to consecutive addresses. The address wraps within its 64-byte page.
- R7: A read (opcode 0x03, two address bytes) returns bytes from consecutive addresses. The address wraps from the last array byte to byte 0. Address bits above the array size are ignored.
- R8: During a busy period, reads, writes and latch changes are ignored and so_oe stays low. A status read (opcode 0x05) still works and shows bit0 set.
- R9: HOLD_n is taken into account only while SCK is low. While held, so_oe is low and SCK and SI edges are ignored. The transfer resumes at the same bit once HOLD_n is high again.
- R10: An unrecognised opcode makes the rest of the frame ignored. so_oe stays low and no state changes.
- R11: SPI mode 3 (SCK idle high) gives the same results as mode 0.
- R12: Opcode 0x01 with one data byte, when the latch is set, loads status bits 3:2 (the protect field) at the end of the busy period. Protect field 1, 2 or 3 blocks writes whose start address lies in the top quarter, the top half or the whole array. A blocked write is discarded and the latch stays set.
- R13: SI is sampled on SCK rising edges. SO changes only after an SCK falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (stands in for power-on reset) |
| sck | input | 1 | SPI serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The hardest situations to reach from the ports are the short busy window and a pause in the middle of a read. The bench starts a write and immediately issues a status read, a read and a latch-set inside the same busy window, then observes so_oe and the later status. For the pause, it reads one byte, drops HOLD_n while SCK is low, and toggles SCK and SI while held. It then checks that the next byte read after resuming is the correct neighbour. A frame cut three bits into a byte covers the discard path.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 64,
  parameter int ADDR_BYTES  = 2,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int MW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WREN = 8'h06;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_WDATA, S_RDATA, S_RSR, S_WSR, S_IGN} st_t;

  logic [7:0]          mem  [MEM_BYTES];
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  st_t                 st;
  logic [2:0]          bcnt;
  logic [1:0]          acnt;
  logic [6:0]          sh;
  logic [MW-1:0]       ash, ridx, wstart;
  logic [PW-1:0]       woff;
  logic [7:0]          osh;
  logic [1:0]          bp, bp_new;
  logic [CW-1:0]       bcount;
  logic so_r, sck_q, cs_q, held, wel, sr_pend, wgot, is_rd;

  wire busy      = bcount != '0;
  wire rise      = !cs_n && !held && sck && !sck_q;
  wire fall      = !cs_n && !held && !sck && sck_q;
  wire cs_rise   = cs_n && !cs_q;
  wire [7:0] byte_in = {sh, si};
  wire [MW-1:0] addr_in = {ash[MW-2:0], si};
  wire [7:0] status  = {4'b0, bp, wel, busy};
  wire wr_prot = (bp == 2'd3) ||
                 (bp == 2'd2 && wstart >= MW'(MEM_BYTES / 2)) ||
                 (bp == 2'd1 && wstart >= MW'(MEM_BYTES - MEM_BYTES / 4));
  wire wr_ok = st == S_WDATA && bcnt == 3'd0 && wgot && wel && !wr_prot;
  wire sr_ok = st == S_WSR && bcnt == 3'd0 && wgot && wel;

  assign so    = so_r;
  assign so_oe = !cs_n && !held && (st == S_RDATA || st == S_RSR);

  always_ff @(posedge clk) begin
    if (rise && st == S_WDATA && bcnt == 3'd7) pbuf[woff] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst && bcount == CW'(1) && !sr_pend)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[{wstart[MW-1:PW], PW'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_CMD; bcnt <= '0; acnt <= '0; sh <= '0; ash <= '0; osh <= '0;
      so_r <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1; held <= 1'b0; wel <= 1'b0;
      sr_pend <= 1'b0; wgot <= 1'b0; is_rd <= 1'b0; bp <= '0; bp_new <= '0;
      ridx <= '0; wstart <= '0; woff <= '0; bcount <= '0; pvalid <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) held <= 1'b0;
      else if (!sck) held <= !hold_n;

      if (busy) begin
        bcount <= bcount - CW'(1);
        if (bcount == CW'(1) && sr_pend) begin
          bp <= bp_new;
          sr_pend <= 1'b0;
        end
      end

      if (cs_n) begin
        st <= S_CMD; bcnt <= '0; acnt <= '0;
        if (cs_rise && (wr_ok || sr_ok)) begin
          bcount  <= CW'(BUSY_CYCLES);
          wel     <= 1'b0;
          sr_pend <= sr_ok;
        end
      end else if (rise) begin
        sh   <= byte_in[6:0];
        ash  <= addr_in;
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          case (st)
            S_CMD: begin
              is_rd <= byte_in == OP_READ;
              if (busy && byte_in != OP_RDSR) st <= S_IGN;
              else case (byte_in)
                OP_WREN:  begin wel <= 1'b1; st <= S_IGN; end
                OP_WRDI:  begin wel <= 1'b0; st <= S_IGN; end
                OP_RDSR:  begin osh <= status; st <= S_RSR; end
                OP_WRSR:  begin wgot <= 1'b0; st <= S_WSR; end
                OP_READ, OP_WRITE: st <= S_ADDR;
                default:  st <= S_IGN;
              endcase
            end
            S_ADDR: begin
              acnt <= acnt + 2'd1;
              if (acnt == 2'(ADDR_BYTES - 1)) begin
                if (is_rd) begin
                  osh  <= mem[addr_in];
                  ridx <= addr_in + MW'(1);
                  st   <= S_RDATA;
                end else begin
                  wstart <= addr_in;
                  woff   <= addr_in[PW-1:0];
                  pvalid <= '0;
                  wgot   <= 1'b0;
                  st     <= S_WDATA;
                end
              end
            end
            S_WDATA: begin
              pvalid[woff] <= 1'b1;
              woff <= woff + PW'(1);
              wgot <= 1'b1;
            end
            S_RDATA: begin
              osh  <= mem[ridx];
              ridx <= ridx + MW'(1);
            end
            S_RSR: osh <= status;
            S_WSR: begin bp_new <= byte_in[3:2]; wgot <= 1'b1; end
            default: ;
          endcase
        end
      end else if (fall && (st == S_RDATA || st == S_RSR)) begin
        so_r <= osh[7];
        osh  <= {osh[6:0], 1'b0};
      end
    end
  end
endmodule

module spi_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so,
  input logic so_oe,
  input logic busy,
  input logic wel
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (!so_oe && !busy && !wel));

  a_r4_busy_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

  a_r8_latch_low_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wel);

  a_r9_hold_floats_so: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !hold_n && !sck) |=> !so_oe);

  a_r13_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe) && so != $past(so)) |-> (!$past(sck) && $past(sck, 2)));
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so(so), .so_oe(so_oe), .busy(busy), .wel(wel)
);

// File: tb/spi_eeprom_slave_tb.sv
`timescale 1ns/1ps
module spi_eeprom_slave_tb;
  localparam int H    = 4;
  localparam int BUSY = 1000;
  localparam logic [23:0] VEC [6] = '{24'h0010A5, 24'h01113C, 24'h0222F0,
                                      24'h03000F, 24'h804481, 24'h01FF7E};

  logic clk = 0, rst = 1, sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0, glitch = 0, oe_cnt = 0, mark = 0;
  bit mode3 = 0;
  logic [7:0] rb [8];
  logic [7:0] s, d;

  spi_eeprom_slave #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe));

  always #2.5 clk = ~clk;
  always @(negedge clk) if (so_oe) oe_cnt++;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic rbit);
    logic pre;
    if (mode3) sck = 0;
    si = b;
    tick(H);
    rbit = so; pre = so;
    sck = 1;
    tick(H);
    if (so_oe && so !== pre) glitch++;
    if (!mode3) sck = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      xbit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic sel(); sck = mode3; tick(H); cs_n = 0; tick(H); endtask
  task automatic desel(); tick(H); cs_n = 1; tick(2 * H); endtask
  task automatic op1(input logic [7:0] op); logic [7:0] x; sel(); xfer(op, x); desel(); endtask
  task automatic rdsr(output logic [7:0] st);
    logic [7:0] x; sel(); xfer(8'h05, x); xfer(8'h00, st); desel();
  endtask
  task automatic wrsr(input logic [7:0] v);
    logic [7:0] x; sel(); xfer(8'h01, x); xfer(v, x); desel();
  endtask
  task automatic wr(input logic [15:0] a, input int n, input logic [31:0] dat);
    logic [7:0] x;
    sel(); xfer(8'h02, x); xfer(a[15:8], x); xfer(a[7:0], x);
    for (int i = 0; i < n; i++) xfer(dat[31 - 8*i -: 8], x);
    desel();
  endtask
  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] x;
    sel(); xfer(8'h03, x); xfer(a[15:8], x); xfer(a[7:0], x);
    for (int i = 0; i < n; i++) xfer(8'h00, rb[i]);
    desel();
  endtask
  task automatic wait_busy(); tick(BUSY + 20); endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
  end

  initial begin
    tick(5); rst = 0; tick(2);
    check("R1 so_oe after reset", so_oe, 0);
    rdsr(s); check("R1 status after reset", s, 8'h00);

    // R10: unknown opcode
    mark = oe_cnt;
    sel(); xfer(8'hAB, d); xfer(8'h06, d); xfer(8'h05, d); desel();
    check("R10 so_oe stays low", oe_cnt - mark, 0);
    rdsr(s); check("R10 no state change", s, 8'h00);

    // R2: latch set and clear
    op1(8'h06); rdsr(s); check("R2 latch set", s, 8'h02);
    op1(8'h04); rdsr(s); check("R2 latch cleared", s, 8'h00);

    // R4 and R8: accepted write and the busy window
    op1(8'h06); wr(16'h0050, 1, 32'h22000000);
    rdsr(s); check("R4 busy set, latch cleared", s, 8'h01);
    mark = oe_cnt;
    rd(16'h0050, 1);
    check("R8 read ignored while busy", oe_cnt - mark, 0);
    op1(8'h06);
    rdsr(s); check("R8 status read while busy", s, 8'h01);
    wait_busy();
    rdsr(s); check("R8 latch set ignored while busy", s, 8'h00);
    rd(16'h0050, 1); check("R4 data after busy", rb[0], 8'h22);

    // R3: write without latch
    wr(16'h0050, 1, 32'h11000000);
    rdsr(s); check("R3 no busy without latch", s, 8'h00);
    rd(16'h0050, 1); check("R3 array unchanged", rb[0], 8'h22);

    // R4: vector table
    for (int i = 0; i < 6; i++) begin
      op1(8'h06); wr(VEC[i][23:8], 1, {VEC[i][7:0], 24'h0}); wait_busy();
      rd(VEC[i][23:8], 1); check("R4 vector readback", rb[0], VEC[i][7:0]);
    end

    // R5: partial byte and empty data
    op1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h99, d);
    xbit(1'b1, d[0]); xbit(1'b0, d[0]); xbit(1'b1, d[0]); desel();
    rdsr(s); check("R5 partial frame discarded", s, 8'h02);
    rd(16'h0050, 1); check("R5 array unchanged", rb[0], 8'h22);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); desel();
    rdsr(s); check("R5 empty data discarded", s, 8'h02);
    op1(8'h04);

    // R6: page wrap
    op1(8'h06); wr(16'h007E, 4, 32'h01020304); wait_busy();
    rd(16'h0040, 2);
    check("R6 wrapped byte 0", rb[0], 8'h03);
    check("R6 wrapped byte 1", rb[1], 8'h04);
    rd(16'h007E, 2);
    check("R6 page tail 0", rb[0], 8'h01);
    check("R6 page tail 1", rb[1], 8'h02);

    // R7: read wraps at array end
    op1(8'h06); wr(16'h03FF, 1, 32'hC3000000); wait_busy();
    op1(8'h06); wr(16'h0000, 1, 32'h3C000000); wait_busy();
    rd(16'h03FF, 2);
    check("R7 last byte", rb[0], 8'hC3);
    check("R7 wrap to zero", rb[1], 8'h3C);

    // R9: hold in the middle of a read
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h7E, d);
    xfer(8'h00, d); check("R9 byte before hold", d, 8'h01);
    hold_n = 0; tick(H);
    check("R9 so_oe low while held", so_oe, 0);
    mark = oe_cnt;
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1; tick(H); sck = 0; tick(H);
    end
    check("R9 no drive during hold", oe_cnt - mark, 0);
    hold_n = 1; tick(H);
    xfer(8'h00, d); check("R9 byte after resume", d, 8'h02);
    desel();

    // R12: protect field
    op1(8'h06); wr(16'h03F0, 1, 32'h5A000000); wait_busy();
    op1(8'h06); wrsr(8'h08); wait_busy();
    rdsr(s); check("R12 protect field loaded", s, 8'h08);
    op1(8'h06); wr(16'h03F0, 1, 32'h77000000);
    rdsr(s); check("R12 protected write discarded", s, 8'h0A);
    rd(16'h03F0, 1); check("R12 protected byte kept", rb[0], 8'h5A);
    wr(16'h0005, 1, 32'h66000000); wait_busy();
    rd(16'h0005, 1); check("R12 lower half writable", rb[0], 8'h66);
    op1(8'h06); wrsr(8'h00); wait_busy();
    rdsr(s); check("R12 protect cleared", s, 8'h00);

    // R11: mode 3
    mode3 = 1;
    op1(8'h06); rdsr(s); check("R11 mode3 status", s, 8'h02);
    wr(16'h0200, 2, 32'h96690000); wait_busy();
    rd(16'h0200, 2);
    check("R11 mode3 byte 0", rb[0], 8'h96);
    check("R11 mode3 byte 1", rb[1], 8'h69);
    mode3 = 0;

    check("R13 so stable between falling edges", glitch, 0);
    summary();
  end
endmodule